// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This block gathers five interrupt sources and hands the CPU one request line with a vector address. The five sources are two active-low external pins, two timer overflow events and a serial flag pair. Each source is gated by its own enable bit and by a master enable. Any source can be raised to the high level through a per-source priority bit. Within a level, a fixed scan order breaks ties. A two-bit in-service stack records which levels are being serviced. A high-level request can interrupt a low-level routine. A low-level request waits until no routine is active.

Each external pin can be set to sense a falling edge or a low level. A falling edge latches a flag. A low level is followed directly, without a latch. Timer flags clear themselves when their vector is taken. Edge flags clear when the routine that serves them returns. The serial request stays up until the serial flags are dropped at their origin. The CPU side consists of an acknowledge strobe, sampled together with the vector in the same cycle, and a return strobe.

Configuration goes through a small write port with three registers. The request, level and vector outputs are combinational from the flags, configuration, in-service state and pin levels. This lets the CPU take a vector in the same cycle it is raised.

Top module: `vec_irq_ctrl`

## Requirements
- R1: Source index i (0 = external 0, 1 = timer 0, 2 = external 1, 3 = timer 1, 4 = serial) presents vector 0x0003 + 8*i, giving 0x0003, 0x000B, 0x0013, 0x001B and 0x0023. While there is no request, irq_vec reads 0.
- R2: Among eligible requests of the same level, the lowest index wins: external 0, then timer 0, external 1, timer 1, serial.
- R3: Writing cfg_addr 1 loads the priority bits; bit i belongs to source i. A source whose bit is 1 is served at level 1 (irq_lvl = 1) ahead of every level-0 source.
- R4: While only level 0 is in service, only level-1 sources may request. While level 1 is in service, irq_req stays low. A level-0 source waits until the in-service state is empty.
- R5: After reset every enable is 0 and irq_req is low. Writing cfg_addr 0 sets the master enable from bit 7 and source enable i from bit i. A source requests only when both its enable and the master enable are 1.
- R6: Writing cfg_addr 2 sets the trigger bits: bit 0 for external 0, bit 1 for external 1. With its bit at 1, a high-to-low transition on the pin sets ext_flag the following cycle, and the flag is the request. With its bit at 0, the request is the pin being low, and ext_flag stays 0.
- R7: An edge flag clears when the return strobe ends the routine of that source. A return in the same cycle as a new falling edge still clears it. Falling edges seen during that routine leave no pending request afterwards.
- R8: A one-cycle pulse on tmr_ovf[k] sets tmr_flag[k]. The flag clears when the vector of timer k is acknowledged, unless a new overflow arrives in that same cycle, in which case it stays set.
- R9: The serial request is ser_rx_flag OR ser_tx_flag. Acknowledging it clears nothing.
- R10: An accepted acknowledge sets the in-service bit of irq_lvl. A return clears the highest set bit. A return with nothing in service has no effect. An acknowledge with irq_req low, or in the same cycle as a return, has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Register select: 0 enables, 1 priority, 2 trigger type |
| cfg_wdata | input | 8 | Configuration write data |
| ext_n | input | 2 | Active-low external interrupt pins |
| tmr_ovf | input | 2 | Timer overflow pulses |
| ser_rx_flag | input | 1 | Serial receive flag |
| ser_tx_flag | input | 1 | Serial transmit flag |
| cpu_ack | input | 1 | CPU takes the presented vector |
| cpu_reti | input | 1 | CPU returns from the current routine |
| irq_req | output | 1 | Interrupt request to the CPU |
| irq_vec | output | 16 | Vector address of the winning source |
| irq_lvl | output | 1 | Priority level of the winning source |
| insvc | output | 2 | In-service bits, one per level |
| ext_flag | output | 2 | Latched edge flags of the external pins |
| tmr_flag | output | 2 | Timer overflow flags |

## Verification
The bench uses the default parameters: a 16-bit vector with base 3 and stride 8. Under these settings the five vector addresses are exactly the literal values in R1, so directed checks can compare against fixed constants. The two-entry in-service stack and the pairing of two external pins with two timers give every combination of level, source kind and nesting depth. With only five sources and three configuration registers, random priority, enable and trigger writes mixed with random acknowledges and returns reach preemption, same-cycle set/clear collisions and blocked low-level requests many times within a few thousand cycles.

// File: rtl/ivc_pkg.sv
package ivc_pkg;
  localparam int unsigned EXT_N  = 2;
  localparam int unsigned SRC_N  = 2 * EXT_N + 1;
  localparam int unsigned SRC_IW = $clog2(SRC_N);
  localparam int unsigned LVL_N  = 2;
  localparam int unsigned LVL_W  = 1;

  typedef logic [SRC_IW-1:0] src_idx_t;

  typedef struct packed {
    logic     hit;
    src_idx_t idx;
  } pick_t;

  // lowest set index of a request mask
  function automatic pick_t pick_first(input logic [SRC_N-1:0] m);
    pick_t r;
    r.hit = 1'b0;
    r.idx = '0;
    for (int i = SRC_N - 1; i >= 0; i--) begin
      if (m[i]) begin
        r.hit = 1'b1;
        r.idx = SRC_IW'(i);
      end
    end
    return r;
  endfunction

  // vector address of a source index
  function automatic int unsigned vec_of(input src_idx_t idx, input int unsigned base,
                                         input int unsigned stride);
    return base + 32'(idx) * stride;
  endfunction

  // in-service stack pop: clear the highest set bit
  function automatic logic [LVL_N-1:0] stack_pop(input logic [LVL_N-1:0] s);
    logic [LVL_N-1:0] r;
    logic found;
    r = s;
    found = 1'b0;
    for (int i = LVL_N - 1; i >= 0; i--) begin
      if (!found && s[i]) begin
        r[i]  = 1'b0;
        found = 1'b1;
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/ivc_src_latch.sv
module ivc_src_latch
  import ivc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EXT_N-1:0] ext_n,
  input  logic [EXT_N-1:0] edge_mode,
  input  logic [EXT_N-1:0] tmr_ovf,
  input  logic             ser_rx,
  input  logic             ser_tx,
  input  logic             ack_fire,
  input  src_idx_t         ack_src,
  input  logic             ret_fire,
  input  src_idx_t         ret_src,
  output logic [SRC_N-1:0] raw_req,
  output logic [EXT_N-1:0] ext_flag,
  output logic [EXT_N-1:0] tmr_flag
);
  // source 2k is external pin k, source 2k+1 is timer k
  for (genvar k = 0; k < EXT_N; k++) begin : g_pair
    localparam src_idx_t EIDX = src_idx_t'(2 * k);
    localparam src_idx_t TIDX = src_idx_t'(2 * k + 1);

    logic pin_prev_q, eflag_q, tflag_q;
    logic fall, eset, eclr, tclr;

    always_comb begin
      fall = pin_prev_q & ~ext_n[k];
      eset = edge_mode[k] & fall;
      eclr = ret_fire & (ret_src == EIDX);
      tclr = ack_fire & (ack_src == TIDX);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pin_prev_q <= 1'b1;
        eflag_q    <= 1'b0;
        tflag_q    <= 1'b0;
      end else begin
        pin_prev_q <= ext_n[k];
        // return clear beats a coincident edge; level mode holds the flag at 0
        eflag_q    <= edge_mode[k] & (eflag_q | eset) & ~eclr;
        // a fresh overflow beats a coincident acknowledge
        tflag_q    <= tmr_ovf[k] | (tflag_q & ~tclr);
      end
    end

    assign ext_flag[k]      = eflag_q;
    assign tmr_flag[k]      = tflag_q;
    assign raw_req[2*k]     = edge_mode[k] ? eflag_q : ~ext_n[k];
    assign raw_req[2*k + 1] = tflag_q;
  end

  assign raw_req[SRC_N-1] = ser_rx | ser_tx;
endmodule

// File: rtl/ivc_resolver.sv
module ivc_resolver
  import ivc_pkg::*;
#(
  parameter int unsigned VEC_W      = 16,
  parameter int unsigned VEC_BASE   = 3,
  parameter int unsigned VEC_STRIDE = 8
) (
  input  logic [SRC_N-1:0] pending,
  input  logic [SRC_N-1:0] prio,
  input  logic [LVL_N-1:0] insvc,
  output logic             req,
  output logic             lvl,
  output src_idx_t         src,
  output logic [VEC_W-1:0] vec
);
  pick_t hi_pick, lo_pick;
  logic  hi_ok, lo_ok;

  always_comb begin
    hi_pick = pick_first(pending & prio);
    lo_pick = pick_first(pending & ~prio);
    hi_ok   = hi_pick.hit & ~insvc[LVL_N-1];
    lo_ok   = lo_pick.hit & (insvc == '0);
    req     = hi_ok | lo_ok;
    lvl     = hi_ok;
    src     = hi_ok ? hi_pick.idx : lo_pick.idx;
    vec     = req ? VEC_W'(vec_of(src, VEC_BASE, VEC_STRIDE)) : '0;
  end
endmodule

// File: rtl/ivc_svc_stack.sv
module ivc_svc_stack
  import ivc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [LVL_W-1:0] push_lvl,
  input  src_idx_t         push_src,
  input  logic             pop,
  output logic [LVL_N-1:0] busy,
  output src_idx_t         top_src
);
  logic [LVL_N-1:0] busy_q;
  src_idx_t         owner_q [LVL_N];

  always_comb begin
    top_src = owner_q[0];
    for (int i = 1; i < LVL_N; i++) begin
      if (busy_q[i]) top_src = owner_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= '0;
      for (int i = 0; i < LVL_N; i++) owner_q[i] <= '0;
    end else if (pop) begin
      busy_q <= stack_pop(busy_q);
    end else if (push) begin
      busy_q[push_lvl]  <= 1'b1;
      owner_q[push_lvl] <= push_src;
    end
  end

  assign busy = busy_q;
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
  import ivc_pkg::*;
#(
  parameter int unsigned VEC_W      = 16,
  parameter int unsigned VEC_BASE   = 3,
  parameter int unsigned VEC_STRIDE = 8,
  parameter int unsigned CFG_AW     = 2,
  parameter int unsigned CFG_DW     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [CFG_DW-1:0] cfg_wdata,
  input  logic [EXT_N-1:0]  ext_n,
  input  logic [EXT_N-1:0]  tmr_ovf,
  input  logic              ser_rx_flag,
  input  logic              ser_tx_flag,
  input  logic              cpu_ack,
  input  logic              cpu_reti,
  output logic              irq_req,
  output logic [VEC_W-1:0]  irq_vec,
  output logic              irq_lvl,
  output logic [LVL_N-1:0]  insvc,
  output logic [EXT_N-1:0]  ext_flag,
  output logic [EXT_N-1:0]  tmr_flag
);
  localparam logic [CFG_AW-1:0] ADDR_EN   = CFG_AW'(0);
  localparam logic [CFG_AW-1:0] ADDR_PRIO = CFG_AW'(1);
  localparam logic [CFG_AW-1:0] ADDR_TRIG = CFG_AW'(2);
  localparam int unsigned       GLOB_BIT  = CFG_DW - 1;

  logic             glob_en_q;
  logic [SRC_N-1:0] src_en_q;
  logic [SRC_N-1:0] prio_q;
  logic [EXT_N-1:0] trig_q;

  logic [SRC_N-1:0] raw_req, pending;
  logic             ack_fire, ret_fire, win_lvl;
  src_idx_t         win_src, ret_src;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      glob_en_q <= 1'b0;
      src_en_q  <= '0;
      prio_q    <= '0;
      trig_q    <= '0;
    end else if (cfg_we) begin
      unique case (cfg_addr)
        ADDR_EN: begin
          glob_en_q <= cfg_wdata[GLOB_BIT];
          src_en_q  <= cfg_wdata[SRC_N-1:0];
        end
        ADDR_PRIO: prio_q <= cfg_wdata[SRC_N-1:0];
        ADDR_TRIG: trig_q <= cfg_wdata[EXT_N-1:0];
        default: ;
      endcase
    end
  end

  assign pending  = raw_req & src_en_q & {SRC_N{glob_en_q}};
  assign ret_fire = cpu_reti & (insvc != '0);
  assign ack_fire = cpu_ack & irq_req & ~cpu_reti;

  ivc_src_latch u_src (
    .clk       (clk),
    .rst_n     (rst_n),
    .ext_n     (ext_n),
    .edge_mode (trig_q),
    .tmr_ovf   (tmr_ovf),
    .ser_rx    (ser_rx_flag),
    .ser_tx    (ser_tx_flag),
    .ack_fire  (ack_fire),
    .ack_src   (win_src),
    .ret_fire  (ret_fire),
    .ret_src   (ret_src),
    .raw_req   (raw_req),
    .ext_flag  (ext_flag),
    .tmr_flag  (tmr_flag)
  );

  ivc_resolver #(
    .VEC_W      (VEC_W),
    .VEC_BASE   (VEC_BASE),
    .VEC_STRIDE (VEC_STRIDE)
  ) u_res (
    .pending (pending),
    .prio    (prio_q),
    .insvc   (insvc),
    .req     (irq_req),
    .lvl     (win_lvl),
    .src     (win_src),
    .vec     (irq_vec)
  );

  ivc_svc_stack u_stack (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (ack_fire),
    .push_lvl (win_lvl),
    .push_src (win_src),
    .pop      (ret_fire),
    .busy     (insvc),
    .top_src  (ret_src)
  );

  assign irq_lvl = win_lvl;
endmodule

// File: rtl/ivc_chk.sv
module ivc_chk
  import ivc_pkg::*;
#(
  parameter int unsigned VEC_W      = 16,
  parameter int unsigned VEC_BASE   = 3,
  parameter int unsigned VEC_STRIDE = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             glob_en,
  input logic             irq_req,
  input logic [VEC_W-1:0] irq_vec,
  input logic             irq_lvl,
  input logic [LVL_N-1:0] insvc,
  input logic             ack_fire,
  input logic             ret_fire,
  input src_idx_t         ack_src,
  input logic [EXT_N-1:0] tmr_ovf,
  input logic [EXT_N-1:0] tmr_flag
);
  // R5
  no_req_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !glob_en |-> !irq_req);

  // R1
  vec_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (32'(irq_vec) >= VEC_BASE) &&
                ((32'(irq_vec) - VEC_BASE) % VEC_STRIDE == 0) &&
                (32'(irq_vec) <= VEC_BASE + (SRC_N - 1) * VEC_STRIDE));

  // R4
  hi_busy_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    insvc[1] |-> !irq_req);

  // R4
  lo_busy_only_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (insvc == 2'b01 && irq_req) |-> irq_lvl);

  // R10
  push_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_fire && irq_lvl) |=> insvc[1]);

  // R10
  pop_nested_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_fire && insvc == 2'b11) |=> (insvc == 2'b01));

  // R8
  tmr0_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_fire && ack_src == src_idx_t'(1) && !tmr_ovf[0]) |=> !tmr_flag[0]);
endmodule

bind vec_irq_ctrl ivc_chk #(
  .VEC_W      (VEC_W),
  .VEC_BASE   (VEC_BASE),
  .VEC_STRIDE (VEC_STRIDE)
) u_ivc_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .glob_en  (glob_en_q),
  .irq_req  (irq_req),
  .irq_vec  (irq_vec),
  .irq_lvl  (irq_lvl),
  .insvc    (insvc),
  .ack_fire (ack_fire),
  .ret_fire (ret_fire),
  .ack_src  (win_src),
  .tmr_ovf  (tmr_ovf),
  .tmr_flag (tmr_flag)
);

// File: tb/tb_vec_irq_ctrl.sv
module tb_vec_irq_ctrl;
  localparam int CLK_PERIOD   = 10;
  localparam int WATCHDOG_CYC = 150000;
  localparam int RAND_CYC     = 4000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic [1:0] ext_n = 2'b11, tmr_ovf = 2'b00;
  logic ser_rx = 1'b0, ser_tx = 1'b0, cpu_ack = 1'b0, cpu_reti = 1'b0;
  logic irq_req, irq_lvl;
  logic [15:0] irq_vec;
  logic [1:0] insvc, ext_flag, tmr_flag;

  vec_irq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .ext_n(ext_n), .tmr_ovf(tmr_ovf), .ser_rx_flag(ser_rx), .ser_tx_flag(ser_tx),
    .cpu_ack(cpu_ack), .cpu_reti(cpu_reti), .irq_req(irq_req), .irq_vec(irq_vec),
    .irq_lvl(irq_lvl), .insvc(insvc), .ext_flag(ext_flag), .tmr_flag(tmr_flag)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  string tag_req = "R2";

  // reference model state
  bit       m_glob;
  bit [4:0] m_en, m_prio;
  bit [1:0] m_mode, m_prev, m_eflag, m_tflag, m_insvc;
  int       m_act [2];

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp, string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic bit m_raw(int i);
    if (i == 4) return ser_rx | ser_tx;
    if (i % 2 == 0) return m_mode[i/2] ? m_eflag[i/2] : !ext_n[i/2];
    return m_tflag[(i-1)/2];
  endfunction

  // winner by ranking key: level first, then lower index
  function automatic int m_pick();
    int best, best_key, key;
    bit hi;
    best = -1; best_key = -1;
    for (int i = 0; i < 5; i++) begin
      if (m_raw(i) && m_en[i] && m_glob) begin
        hi = m_prio[i];
        if (hi ? !m_insvc[1] : (m_insvc == 2'b00)) begin
          key = (hi ? 100 : 0) + (10 - i);
          if (key > best_key) begin best_key = key; best = i; end
        end
      end
    end
    return best;
  endfunction

  task automatic tick();
    int w, top;
    bit rf, af, set, clr;
    #1;
    w = m_pick();
    chk(tag_req, irq_req, (w >= 0), "irq_req");
    if (w >= 0) begin
      chk("R1", irq_vec, 3 + 8 * w, "irq_vec");
      chk("R3", irq_lvl, m_prio[w], "irq_lvl");
    end else chk("R1", irq_vec, 0, "irq_vec idle");
    chk("R10", insvc, m_insvc, "insvc");
    chk("R6", ext_flag, m_eflag, "ext_flag");
    chk("R8", tmr_flag, m_tflag, "tmr_flag");
    rf  = cpu_reti && (m_insvc != 2'b00);
    af  = cpu_ack && (w >= 0) && !cpu_reti;
    top = m_insvc[1] ? 1 : 0;
    for (int k = 0; k < 2; k++) begin
      set = m_mode[k] && m_prev[k] && !ext_n[k];
      clr = rf && (m_act[top] == 2 * k);
      m_eflag[k] = m_mode[k] && (m_eflag[k] || set) && !clr;
      clr = af && (w == 2 * k + 1);
      m_tflag[k] = tmr_ovf[k] || (m_tflag[k] && !clr);
    end
    m_prev = ext_n;
    if (rf) begin
      if (m_insvc[1]) m_insvc[1] = 1'b0; else m_insvc[0] = 1'b0;
    end else if (af) begin
      m_insvc[m_prio[w]] = 1'b1;
      m_act[m_prio[w]]   = w;
    end
    if (cfg_we) begin
      case (cfg_addr)
        2'd0: begin m_glob = cfg_wdata[7]; m_en = cfg_wdata[4:0]; end
        2'd1: m_prio = cfg_wdata[4:0];
        2'd2: m_mode = cfg_wdata[1:0];
        default: ;
      endcase
    end
    @(posedge clk);
    @(negedge clk);
    cfg_we = 1'b0; cpu_ack = 1'b0; cpu_reti = 1'b0; tmr_ovf = 2'b00;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    tick();
  endtask

  task automatic look(string tag, bit exp_req, logic [15:0] exp_vec);
    #1;
    chk(tag, irq_req, exp_req, "directed irq_req");
    chk(tag, irq_vec, exp_vec, "directed irq_vec");
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (WATCHDOG_CYC) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R10 watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    int unsigned seed_init;
    seed_init = $urandom(32'd4242);
    m_glob = 0; m_en = 0; m_prio = 0; m_mode = 0; m_prev = 2'b11;
    m_eflag = 0; m_tflag = 0; m_insvc = 0; m_act[0] = 0; m_act[1] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R5: reset state, pin low but nothing enabled
    tag_req = "R5";
    #1;
    chk("R5", irq_req, 0, "reset irq_req");
    chk("R5", insvc, 0, "reset insvc");
    chk("R5", {ext_flag, tmr_flag}, 0, "reset flags");
    ext_n = 2'b10;
    tick(); tick();
    look("R5", 0, 16'h0000);
    wr(2'd0, 8'h01);
    look("R5", 0, 16'h0000);
    wr(2'd0, 8'h81);
    look("R1", 1, 16'h0003);

    // R2: scan order inside one level
    tag_req = "R2";
    ext_n = 2'b00; ser_rx = 1'b1; tmr_ovf = 2'b11;
    tick();
    wr(2'd0, 8'h9F);
    look("R2", 1, 16'h0003);
    ext_n = 2'b11;
    look("R2", 1, 16'h000B);
    cpu_ack = 1'b1; tick();
    #1 chk("R8", tmr_flag, 2'b10, "tmr0 cleared by ack");
    look("R4", 0, 16'h0000);
    cpu_reti = 1'b1; tick();
    look("R2", 1, 16'h001B);
    cpu_ack = 1'b1; tick();
    cpu_reti = 1'b1; tick();
    look("R2", 1, 16'h0023);
    cpu_ack = 1'b1; tick();
    cpu_reti = 1'b1; tick();
    look("R9", 1, 16'h0023);
    ser_rx = 1'b0; ser_tx = 1'b1;
    look("R9", 1, 16'h0023);
    ser_tx = 1'b0;
    look("R9", 0, 16'h0000);

    // R3: priority bits
    tag_req = "R3";
    wr(2'd1, 8'h10);
    ext_n = 2'b10; ser_tx = 1'b1;
    look("R3", 1, 16'h0023);
    #1 chk("R3", irq_lvl, 1, "serial at level 1");
    wr(2'd1, 8'h04);
    ext_n = 2'b00;
    look("R3", 1, 16'h0013);

    // R4: preemption and blocking
    tag_req = "R4";
    wr(2'd1, 8'h10);
    ser_tx = 1'b0; ext_n = 2'b10;
    look("R4", 1, 16'h0003);
    cpu_ack = 1'b1; tick();
    look("R4", 0, 16'h0000);
    ser_tx = 1'b1;
    look("R4", 1, 16'h0023);
    cpu_ack = 1'b1; tick();
    #1 chk("R10", insvc, 2'b11, "nested insvc");
    look("R4", 0, 16'h0000);
    cpu_reti = 1'b1; tick();
    #1 chk("R10", insvc, 2'b01, "pop high level");
    look("R4", 1, 16'h0023);
    ser_tx = 1'b0; cpu_reti = 1'b1; tick();
    ext_n = 2'b11;
    look("R4", 0, 16'h0000);

    // R6/R7: edge and level sensing
    tag_req = "R6";
    wr(2'd1, 8'h00);
    wr(2'd2, 8'h01);
    ext_n = 2'b10; tick();
    ext_n = 2'b11;
    #1 chk("R6", ext_flag, 2'b01, "edge latched");
    look("R6", 1, 16'h0003);
    cpu_ack = 1'b1; tick();
    ext_n = 2'b10; tick();
    ext_n = 2'b11; tick();
    #1 chk("R7", ext_flag, 2'b01, "flag held in service");
    cpu_reti = 1'b1; tick();
    #1 chk("R7", ext_flag, 2'b00, "flag cleared on return");
    look("R7", 0, 16'h0000);
    ext_n = 2'b01;
    look("R6", 1, 16'h0013);
    #1 chk("R6", ext_flag, 2'b00, "level mode not latched");
    tick();
    ext_n = 2'b11;
    look("R6", 0, 16'h0000);

    // R8: overflow beats acknowledge
    tag_req = "R8";
    tmr_ovf = 2'b01; tick();
    look("R8", 1, 16'h000B);
    cpu_ack = 1'b1; tmr_ovf = 2'b01; tick();
    #1 chk("R8", tmr_flag, 2'b01, "overflow wins over ack");
    cpu_reti = 1'b1; tick();
    cpu_ack = 1'b1; tick();
    cpu_reti = 1'b1; tick();
    #1 chk("R8", tmr_flag, 2'b00, "cleared by second ack");

    // R10: ignored strobes
    tag_req = "R10";
    cpu_reti = 1'b1; tick();
    #1 chk("R10", insvc, 2'b00, "empty return ignored");
    cpu_ack = 1'b1; tick();
    #1 chk("R10", insvc, 2'b00, "ack without request ignored");
    tmr_ovf = 2'b10; tick();
    cpu_ack = 1'b1; cpu_reti = 1'b1; tick();
    #1 chk("R10", insvc, 2'b00, "ack with return ignored");
    #1 chk("R10", tmr_flag, 2'b10, "flag kept when ack ignored");
    cpu_ack = 1'b1; tick();
    cpu_reti = 1'b1; tick();

    // random phase, checked against the model every cycle
    tag_req = "R3";
    for (int n = 0; n < RAND_CYC; n++) begin
      for (int k = 0; k < 2; k++) begin
        if ($urandom_range(7) == 0) ext_n[k] = ~ext_n[k];
        tmr_ovf[k] = ($urandom_range(15) == 0);
      end
      if (ser_rx) ser_rx = ($urandom_range(7) != 0); else ser_rx = ($urandom_range(31) == 0);
      if (ser_tx) ser_tx = ($urandom_range(7) != 0); else ser_tx = ($urandom_range(31) == 0);
      if ($urandom_range(63) == 0) begin
        cfg_we    = 1'b1;
        cfg_addr  = 2'($urandom_range(2));
        cfg_wdata = 8'($urandom_range(255));
        if (cfg_addr == 2'd0 && $urandom_range(3) != 0) cfg_wdata[7] = 1'b1;
      end
      cpu_ack  = ($urandom_range(2) == 0);
      cpu_reti = ($urandom_range(5) == 0);
      tick();
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule